// File: doc/BRIEF.md
# SPI Host Register and FIFO Front End

This block sits between a simple register bus and the serial shift engine of an SPI host. Software writes transmit bytes into a 32-entry transmit FIFO. It reads received bytes from a 32-entry receive FIFO. It programs the mode, chip-select and length fields that the shift engine consumes. The shift engine pulls transmit bytes and pushes received bytes through valid/pop and ready/push handshakes. Clock generation, bit shifting and chip-select timing stay inside that engine.

Four FIFO condition flags report the state of the two queues. Each flag has an interrupt enable in the matching bit position of the enable register. This lets an interrupt handler disarm exactly the sources it has just seen. A sticky abort flag records a transmit byte that arrived while the transmit FIFO was full. A flush bit in the mode register empties both FIFOs for as long as it stays set.

The register window supports two spacings, chosen by an input pin. In wide spacing, registers sit eight bytes apart. In narrow spacing, they sit two bytes apart.

Top module: `spi_host_regfile`

## Requirements
- R1: Register index k (0 = data, 1 = status/select, 2 = mode, 3 = length, 4 = interrupt enable, 5 = auxiliary) decodes from address 8*k when `narrow_bus` is 0 and from address 2*k when it is 1. Any other address reads as zero, and a write to it changes nothing.
- R2: The transmit FIFO holds 32 bytes. `eng_tx_valid` is high while it is non-empty. `eng_tx_data` shows the oldest byte, and `eng_tx_pop` removes that byte.
- R3: A data write while the transmit FIFO holds 32 bytes discards the byte and sets the abort flag (enable register bit 2). Writing the enable register with bit 2 set clears the flag. Writing it with bit 2 clear leaves the flag unchanged.
- R4: `eng_rx_push` stores `eng_rx_data` only while `eng_rx_ready` is high, which means fewer than 32 bytes are stored. A data read returns the oldest byte and removes it. A data read on an empty receive FIFO returns zero and removes nothing.
- R5: Status register bits 7, 6, 5 and 4 read transmit-empty, transmit-full, receive-empty and receive-full. Bits 2..0 hold a writable chip-select field, driven on `cs_ctl`. Bit 3 reads zero.
- R6: `irq` is high in the cycle after any status flag in bits 7..4 is set together with the enable bit in the same position. With all enables clear, `irq` is low from the next cycle on.
- R7: While mode register bit 7 is set, both FIFOs are emptied on every clock edge and engine pushes and pops have no effect. The bit stays set until software writes it to zero.
- R8: Mode register bit 6 drives `loopback`, bit 5 drives `cpol`, bit 4 drives `cpha`, and bits 2..0 drive `clk_div`. Bit 3 always reads zero. The length and auxiliary registers drive `xfer_len` and `aux_cfg`.
- R9: After reset, both FIFOs are empty, the chip-select field, mode, length, auxiliary register, enables and abort flag are zero, and `irq` and `bus_rdata` are zero.
- R10: `bus_rdata` is loaded on the clock edge at which `bus_rd` is high and holds its value when no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow_bus | input | 1 | 1 selects two-byte register spacing, 0 selects eight-byte spacing |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt request |
| eng_tx_valid | output | 1 | Transmit FIFO holds a byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_rx_ready | output | 1 | Receive FIFO has room |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| cs_ctl | output | 3 | Chip-select control field |
| loopback | output | 1 | Loopback select |
| cpol | output | 1 | Clock polarity |
| cpha | output | 1 | Clock phase |
| clk_div | output | 3 | Serial clock divider select |
| xfer_len | output | 8 | Receive length field |
| aux_cfg | output | 8 | Auxiliary configuration byte |

## Verification
Several properties are checked on every cycle. Neither FIFO level ever exceeds its depth. A push into a full queue leaves its level unchanged. A full-queue data write always raises the abort flag. A held flush bit leaves both queues empty. An empty-queue data read returns zero, and clearing all enables silences the interrupt. The bench's scenarios are needed for the rest: byte ordering through each queue, the two address spacings and the holes between registers, the exact status and enable read-back values, and the one-cycle delay from an armed flag to the interrupt.

// File: rtl/spi_hrf_pkg.sv
package spi_hrf_pkg;
  typedef enum logic [2:0] {
    SEL_DATA  = 3'd0,
    SEL_STAT  = 3'd1,
    SEL_MODE  = 3'd2,
    SEL_LEN   = 3'd3,
    SEL_IEN   = 3'd4,
    SEL_AUX   = 3'd5
  } reg_sel_e;

  localparam int NUM_REGS   = 6;
  localparam int WIDE_SHIFT = 3;
  localparam int NARR_SHIFT = 1;
  localparam int MODE_FLUSH = 7;
  localparam int MODE_LOOP  = 6;
  localparam int MODE_CPOL  = 5;
  localparam int MODE_CPHA  = 4;
  localparam int IEN_ABORT  = 2;
endpackage

// File: rtl/spi_hrf_decode.sv
module spi_hrf_decode
  import spi_hrf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              narrow,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_sel_e          sel
);
  localparam int WIDE_SPAN = NUM_REGS << WIDE_SHIFT;
  localparam int NARR_SPAN = NUM_REGS << NARR_SHIFT;

  logic [2:0] raw;
  logic       aligned;
  logic       in_range;

  always_comb begin
    if (narrow) begin
      raw      = 3'(addr >> NARR_SHIFT);
      aligned  = (addr[NARR_SHIFT-1:0] == '0);
      in_range = (int'(addr) < NARR_SPAN);
    end else begin
      raw      = 3'(addr >> WIDE_SHIFT);
      aligned  = (addr[WIDE_SHIFT-1:0] == '0);
      in_range = (int'(addr) < WIDE_SPAN);
    end
    hit = aligned && in_range;
    sel = hit ? reg_sel_e'(raw) : SEL_DATA;
  end
endmodule

// File: rtl/spi_hrf_fifo.sv
module spi_hrf_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign level   = wr_ptr - rd_ptr;
  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R2: stored count never exceeds the configured depth
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH);

  // R3 (transmit side) and R4 (receive side): a push into a full queue is dropped
  assert_full_push_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> $stable(level));
endmodule

// File: rtl/spi_hrf_irq.sv
module spi_hrf_irq #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] enables,
  output logic            irq
);
  logic [NSRC-1:0] armed;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign armed[i] = flags[i] & enables[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |armed;
  end
endmodule

// File: rtl/spi_host_regfile.sv
module spi_host_regfile
  import spi_hrf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int CS_W   = 3,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              narrow_bus,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              eng_tx_valid,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_tx_pop,
  output logic              eng_rx_ready,
  input  logic              eng_rx_push,
  input  logic [DATA_W-1:0] eng_rx_data,
  output logic [CS_W-1:0]   cs_ctl,
  output logic              loopback,
  output logic              cpol,
  output logic              cpha,
  output logic [DIV_W-1:0]  clk_div,
  output logic [DATA_W-1:0] xfer_len,
  output logic [DATA_W-1:0] aux_cfg
);
  localparam int LVL_W  = $clog2(DEPTH) + 1;
  localparam int NFLAGS = 4;
  localparam logic [DATA_W-1:0] MODE_MASK = ~(DATA_W'(1) << 3);

  logic        hit;
  reg_sel_e    sel;
  logic        wr_data, rd_data;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic [DATA_W-1:0] rx_head;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic [CS_W-1:0]   cs_q;
  logic [DATA_W-1:0] mode_q, len_q, aux_q;
  logic [NFLAGS-1:0] ien_q;
  logic        abort_q;
  logic        flush;
  logic [NFLAGS-1:0] flags;
  logic [DATA_W-1:0] rd_mux;

  spi_hrf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .narrow(narrow_bus), .addr(bus_addr), .hit(hit), .sel(sel));

  assign wr_data = bus_wr && hit && (sel == SEL_DATA);
  assign rd_data = bus_rd && hit && (sel == SEL_DATA);
  assign flush   = mode_q[MODE_FLUSH];
  assign flags   = {tx_empty, tx_full, rx_empty, rx_full};

  spi_hrf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(flush), .push(wr_data), .din(bus_wdata),
    .pop(eng_tx_pop), .head(eng_tx_data), .empty(tx_empty), .full(tx_full),
    .level(tx_level));

  spi_hrf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(flush), .push(eng_rx_push), .din(eng_rx_data),
    .pop(rd_data), .head(rx_head), .empty(rx_empty), .full(rx_full),
    .level(rx_level));

  spi_hrf_irq #(.NSRC(NFLAGS)) u_irq (
    .clk(clk), .rst(rst), .flags(flags), .enables(ien_q), .irq(irq));

  assign eng_tx_valid = !tx_empty;
  assign eng_rx_ready = !rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= '0;
      mode_q  <= '0;
      len_q   <= '0;
      aux_q   <= '0;
      ien_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      if (wr_data && tx_full) abort_q <= 1'b1;
      if (bus_wr && hit) begin
        unique case (sel)
          SEL_STAT: cs_q   <= bus_wdata[CS_W-1:0];
          SEL_MODE: mode_q <= bus_wdata & MODE_MASK;
          SEL_LEN:  len_q  <= bus_wdata;
          SEL_IEN: begin
            ien_q <= bus_wdata[DATA_W-1 -: NFLAGS];
            if (bus_wdata[IEN_ABORT]) abort_q <= 1'b0;
          end
          SEL_AUX:  aux_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (sel)
        SEL_DATA: rd_mux = rx_empty ? '0 : rx_head;
        SEL_STAT: begin
          rd_mux[DATA_W-1 -: NFLAGS] = flags;
          rd_mux[CS_W-1:0]           = cs_q;
        end
        SEL_MODE: rd_mux = mode_q;
        SEL_LEN:  rd_mux = len_q;
        SEL_IEN: begin
          rd_mux[DATA_W-1 -: NFLAGS] = ien_q;
          rd_mux[IEN_ABORT]          = abort_q;
        end
        SEL_AUX:  rd_mux = aux_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign cs_ctl   = cs_q;
  assign loopback = mode_q[MODE_LOOP];
  assign cpol     = mode_q[MODE_CPOL];
  assign cpha     = mode_q[MODE_CPHA];
  assign clk_div  = mode_q[DIV_W-1:0];
  assign xfer_len = len_q;
  assign aux_cfg  = aux_q;

  assert_abort_on_full_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_data && tx_full) |=> abort_q);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> (tx_level == '0 && rx_level == '0));

  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_empty) |=> (bus_rdata == '0));

  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> !irq);
endmodule

// File: tb/spi_host_regfile_tb.sv
module spi_host_regfile_tb_top;
  localparam int QD = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic narrow_bus = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, eng_tx_valid, eng_rx_ready, loopback, cpol, cpha;
  logic [7:0] eng_tx_data, xfer_len, aux_cfg;
  logic eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [7:0] eng_rx_data = '0;
  logic [2:0] cs_ctl, clk_div;

  always #10 clk = ~clk;

  spi_host_regfile dut_i (
    .clk(clk), .rst(rst), .narrow_bus(narrow_bus), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq(irq), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
    .eng_tx_pop(eng_tx_pop), .eng_rx_ready(eng_rx_ready), .eng_rx_push(eng_rx_push),
    .eng_rx_data(eng_rx_data), .cs_ctl(cs_ctl), .loopback(loopback), .cpol(cpol),
    .cpha(cpha), .clk_div(clk_div), .xfer_len(xfer_len), .aux_cfg(aux_cfg));

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  // reference model state
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] m_mode, m_len, m_aux, m_rdata;
  logic [2:0] m_cs;
  logic [3:0] m_ien;
  logic       m_abort, m_irq;

  function automatic int reg_index(input logic [5:0] a, input logic nb);
    if (nb) return (a[0] == 1'b0 && a < 6'd12) ? int'(a) / 2 : -1;
    return (a[2:0] == 3'd0 && a < 6'd48) ? int'(a) / 8 : -1;
  endfunction

  function automatic logic [3:0] m_flags();
    return {txq.size() == 0, txq.size() == QD, rxq.size() == 0, rxq.size() == QD};
  endfunction

  always @(posedge clk) begin
    int k, tsz, rsz;
    logic [3:0] fl;
    if (rst) begin
      txq.delete(); rxq.delete();
      m_mode = 0; m_len = 0; m_aux = 0; m_rdata = 0; m_cs = 0;
      m_ien = 0; m_abort = 0; m_irq = 0;
    end else begin
      k   = reg_index(bus_addr, narrow_bus);
      tsz = txq.size();
      rsz = rxq.size();
      fl  = m_flags();
      m_irq = |(fl & m_ien);
      if (bus_rd) begin
        case (k)
          0: m_rdata = (rsz > 0) ? rxq[0] : 8'h00;
          1: m_rdata = {fl, 1'b0, m_cs};
          2: m_rdata = m_mode;
          3: m_rdata = m_len;
          4: m_rdata = {m_ien, 1'b0, m_abort, 2'b00};
          5: m_rdata = m_aux;
          default: m_rdata = 8'h00;
        endcase
      end
      if (m_mode[7]) begin
        txq.delete(); rxq.delete();
      end else begin
        if (eng_tx_pop && tsz > 0) void'(txq.pop_front());
        if (bus_wr && k == 0 && tsz < QD) txq.push_back(bus_wdata);
        if (eng_rx_push && rsz < QD) rxq.push_back(eng_rx_data);
        if (bus_rd && k == 0 && rsz > 0) void'(rxq.pop_front());
      end
      if (bus_wr && k == 0 && tsz == QD) m_abort = 1'b1;
      if (bus_wr) begin
        case (k)
          1: m_cs = bus_wdata[2:0];
          2: m_mode = bus_wdata & 8'hF7;
          3: m_len = bus_wdata;
          4: begin m_ien = bus_wdata[7:4]; if (bus_wdata[2]) m_abort = 1'b0; end
          5: m_aux = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      cmp("R2 tx_valid", {7'd0, eng_tx_valid}, {7'd0, txq.size() > 0});
      if (txq.size() > 0) cmp("R2 tx_data", eng_tx_data, txq[0]);
      cmp("R4 rx_ready", {7'd0, eng_rx_ready}, {7'd0, rxq.size() < QD});
      cmp("R6 irq", {7'd0, irq}, {7'd0, m_irq});
      cmp("R10 rdata", bus_rdata, m_rdata);
      cmp("R5 cs_ctl", {5'd0, cs_ctl}, {5'd0, m_cs});
      cmp("R8 mode", {1'b0, loopback, cpol, cpha, 1'b0, clk_div}, m_mode & 8'h77);
      cmp("R8 len", xfer_len, m_len);
      cmp("R8 aux", aux_cfg, m_aux);
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    cmp(req, act, exp);
  endtask

  function automatic logic [5:0] addr_of(input int k);
    return narrow_bus ? 6'(k * 2) : 6'(k * 8);
  endfunction

  task automatic wr_raw(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_raw(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr_reg(input int k, input logic [7:0] d);
    wr_raw(addr_of(k), d);
  endtask

  task automatic rd_reg(input int k, output logic [7:0] d);
    rd_raw(addr_of(k), d);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: reset state
    @(negedge clk);
    check("R9 irq after reset", {7'd0, irq}, 8'h00);
    check("R9 rdata after reset", bus_rdata, 8'h00);
    rd_reg(1, v); check("R9 R5 status after reset", v, 8'hA0);
    rd_reg(4, v); check("R9 enables after reset", v, 8'h00);
    rd_reg(2, v); check("R9 mode after reset", v, 8'h00);

    // R8: mode fields, bit 3 forced low
    wr_reg(2, 8'h7B);
    rd_reg(2, v); check("R8 mode readback", v, 8'h73);
    check("R8 pins", {1'b0, loopback, cpol, cpha, 1'b0, clk_div}, 8'h73);
    wr_reg(3, 8'hC4); wr_reg(5, 8'h3C);
    check("R8 len pin", xfer_len, 8'hC4);
    check("R8 aux pin", aux_cfg, 8'h3C);

    // R5: chip-select field
    wr_reg(1, 8'hFD);
    rd_reg(1, v); check("R5 status with cs", v, 8'hA5);
    check("R5 cs pin", {5'd0, cs_ctl}, 8'h05);
    wr_reg(1, 8'h00);

    // R2/R3: fill transmit FIFO, overflow
    for (int i = 0; i < QD; i++) wr_reg(0, 8'(8'h10 + i));
    rd_reg(1, v); check("R5 tx full status", v, 8'h60);
    check("R2 tx head", eng_tx_data, 8'h10);
    wr_reg(0, 8'hEE);
    rd_reg(4, v); check("R3 abort set", v, 8'h04);
    wr_reg(4, 8'h00);
    rd_reg(4, v); check("R3 abort kept by zero write", v, 8'h04);
    wr_reg(4, 8'h04);
    rd_reg(4, v); check("R3 abort cleared", v, 8'h00);

    // R6: transmit-full interrupt
    wr_reg(4, 8'h40);
    @(negedge clk); check("R6 irq on tx full", {7'd0, irq}, 8'h01);
    wr_reg(4, 8'h00);
    @(negedge clk); check("R6 irq off", {7'd0, irq}, 8'h00);

    // R2: engine drains in order
    for (int i = 0; i < QD; i++) begin
      @(negedge clk);
      check("R2 drain order", eng_tx_data, 8'(8'h10 + i));
      eng_tx_pop = 1'b1;
    end
    @(negedge clk); eng_tx_pop = 1'b0;
    check("R2 tx empty after drain", {7'd0, eng_tx_valid}, 8'h00);

    // R4: fill receive FIFO with one extra push
    for (int i = 0; i < QD + 1; i++) begin
      @(negedge clk);
      eng_rx_push = 1'b1; eng_rx_data = 8'(8'h40 + i);
    end
    @(negedge clk); eng_rx_push = 1'b0;
    check("R4 rx not ready when full", {7'd0, eng_rx_ready}, 8'h00);
    rd_reg(1, v); check("R5 rx full status", v, 8'h90);
    wr_reg(4, 8'h10);
    @(negedge clk); check("R6 irq on rx full", {7'd0, irq}, 8'h01);
    wr_reg(4, 8'h00);
    for (int i = 0; i < QD; i++) begin
      rd_reg(0, v); check("R4 rx order", v, 8'(8'h40 + i));
    end
    rd_reg(0, v); check("R4 empty read zero", v, 8'h00);

    // R7: flush
    wr_reg(0, 8'hA1); wr_reg(0, 8'hA2);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = 8'h77;
    @(negedge clk); eng_rx_push = 1'b0;
    wr_reg(2, 8'h80);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = 8'h55;
    @(negedge clk); eng_rx_push = 1'b0;
    rd_reg(2, v); check("R7 flush bit held", v, 8'h80);
    rd_reg(1, v); check("R7 both empty", v, 8'hA0);
    wr_reg(2, 8'h00);
    rd_reg(0, v); check("R7 push ignored during flush", v, 8'h00);

    // R1: holes and narrow spacing
    rd_raw(6'h04, v); check("R1 hole reads zero", v, 8'h00);
    wr_raw(6'h2C, 8'h99);
    rd_reg(5, v); check("R1 hole write ignored", v, 8'h3C);
    narrow_bus = 1'b1;
    wr_reg(5, 8'h5A);
    rd_raw(6'h0A, v); check("R1 narrow aux", v, 8'h5A);
    rd_raw(6'h28, v); check("R1 wide address invalid in narrow mode", v, 8'h00);
    wr_raw(6'h03, 8'hFF);
    rd_reg(3, v); check("R1 odd narrow address ignored", v, 8'hC4);

    // R10: rdata held without read
    repeat (3) @(negedge clk);
    check("R10 rdata held", bus_rdata, 8'hC4);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule